// File: doc/BRIEF.md
# Threshold-Gated Interrupt Bid Arbiter

This block decides which of several interrupt sources spread over four channels should be served next. Each channel offers three sources: a receiver, a transmitter and a general "other" source, such as a change of modem state. Every source forms a numeric bid from its level, its type and its channel. The highest enabled bid wins a fixed-length round that resolves the winner one bit at a time, from the most significant bit down. At the end of each round the winner is compared against a programmable threshold. The comparison drives an active-low interrupt request.

The host services the request by pulsing an acknowledge, or by issuing an update command. Either one copies the standing winner into a captured register. That register shows the channel, the source type, the level and an error flag for received data. A channel/type pointer taken from it selects the indirect per-interrupt registers elsewhere in the chip. The register keeps its contents until the next acknowledge or update command.

Top module: `irq_bid_arbiter`

## Requirements
- R1: A bid is 10 bits: level in bits [9:4], type in bits [3:2] (0 other, 1 transmitter, 2 receiver), channel in bits [1:0]. The largest enabled bid wins, so a higher level always beats a lower one whatever the type or channel.
- R2: The level of a receiver is its filled-entry count `rx_fill`. The level of a transmitter is its empty-entry count `tx_empty`. The level of an other source is its programmed value `cos_prio`. Each is a 6-bit field at `[6*ch +: 6]`.
- R3: Only sources whose bit is set in `src_en` take part, where bit index = 3*channel + type. With no source enabled, `cir_valid` captures 0 and `irq_n` stays high.
- R4: `irq_n` is low after a round only when the winning bid is strictly greater than `thresh`. A winner equal to the threshold leaves it high.
- R5: At equal levels a receiver beats a transmitter, which beats an other source. At equal level and type, the higher channel wins.
- R6: A round lasts 22 clock cycles, and `irq_n` changes only at a round boundary.
- R7: Enables, bid fields, error flags and threshold are sampled once at the start of a round. A change made after that sample takes effect only in the following round.
- R8: A cycle with `iack` or `upd_cir` high copies the winner of the last finished round into the captured register: `cir_valid`, `cir_chan`, `cir_type`, `cir_level` and `cir_err`. The register holds that value until the next such cycle.
- R9: `cir_err` is 1 only when the captured winner is a receiver whose `rx_err` bit was set when the round sampled its inputs.
- R10: `gsel` equals `{cir_chan, cir_type}`.
- R11: After reset `irq_n` is high and every captured field, including `gsel`, is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 12 | Per-source enable mask, bit 3*ch+type |
| rx_fill | input | 24 | Receiver filled counts, 6 bits per channel |
| tx_empty | input | 24 | Transmitter empty counts, 6 bits per channel |
| cos_prio | input | 24 | Programmed level of each channel's other source |
| rx_err | input | 4 | Per-channel flag: received data holds an error |
| thresh | input | 10 | Interrupt threshold |
| iack | input | 1 | Interrupt acknowledge, captures the winner |
| upd_cir | input | 1 | Update command, captures the winner |
| irq_n | output | 1 | Active-low interrupt request |
| cir_valid | output | 1 | Captured winner exists |
| cir_err | output | 1 | Captured receiver data has an error |
| cir_chan | output | 2 | Captured channel |
| cir_type | output | 2 | Captured source type |
| cir_level | output | 6 | Captured level |
| gsel | output | 4 | Pointer for indirect per-interrupt registers |

## Verification
The vector table sets patterns in which exactly one field decides the winner, so each comparison rule is checked in isolation. In some patterns the level alone decides. In others a receiver and a transmitter tie on level, a type tie is broken by channel, or an other source with a large programmed value beats busy FIFOs. Further patterns repeat one of these with the strongest bidder masked off. The threshold is set equal to the bid and then one below it, which separates a strict comparison from an inclusive one. A directed test changes the enables either just before or just after the round samples its inputs. A correct 22-cycle round reacts to the first change in the next round and to the second one round later.

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter #(
  parameter int NCH       = 4,
  parameter int CH_W      = 2,
  parameter int TY_W      = 2,
  parameter int LV_W      = 6,
  parameter int ROUND_LEN = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH*3-1:0]         src_en,
  input  logic [NCH*LV_W-1:0]      rx_fill,
  input  logic [NCH*LV_W-1:0]      tx_empty,
  input  logic [NCH*LV_W-1:0]      cos_prio,
  input  logic [NCH-1:0]           rx_err,
  input  logic [LV_W+TY_W+CH_W-1:0] thresh,
  input  logic                     iack,
  input  logic                     upd_cir,
  output logic                     irq_n,
  output logic                     cir_valid,
  output logic                     cir_err,
  output logic [CH_W-1:0]          cir_chan,
  output logic [TY_W-1:0]          cir_type,
  output logic [LV_W-1:0]          cir_level,
  output logic [CH_W+TY_W-1:0]     gsel
);
  localparam int NTY   = 3;
  localparam int NSRC  = NCH * NTY;
  localparam int BID_W = LV_W + TY_W + CH_W;
  localparam int CNT_W = $clog2(ROUND_LEN);
  localparam int BI_W  = $clog2(BID_W);

  logic [BID_W-1:0] bid  [NSRC];
  logic [BID_W-1:0] snap [NSRC];
  logic [NSRC-1:0]  err_vec, err_q, alive, col, hit;
  logic [CNT_W-1:0] cnt;
  logic [BI_W-1:0]  scan_bit;
  logic [BID_W-1:0] acc, th_q, win_bid;
  logic             win_ok, win_err, in_scan, last;
  logic [BID_W+1:0] cir_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    for (genvar t = 0; t < NTY; t++) begin : g_ty
      localparam int S = ch * NTY + t;
      logic [LV_W-1:0] lvl;
      if (t == 2) begin : g_rx
        assign lvl = rx_fill[ch*LV_W +: LV_W];
        assign err_vec[S] = rx_err[ch];
      end else if (t == 1) begin : g_tx
        assign lvl = tx_empty[ch*LV_W +: LV_W];
        assign err_vec[S] = 1'b0;
      end else begin : g_os
        assign lvl = cos_prio[ch*LV_W +: LV_W];
        assign err_vec[S] = 1'b0;
      end
      assign bid[S] = {lvl, TY_W'(t), CH_W'(ch)};
    end
  end

  assign last     = (cnt == CNT_W'(ROUND_LEN - 1));
  assign in_scan  = (cnt != '0) && (cnt <= CNT_W'(BID_W));
  assign scan_bit = BI_W'(CNT_W'(BID_W) - cnt);

  always_comb begin
    for (int s = 0; s < NSRC; s++) col[s] = in_scan ? snap[s][scan_bit] : 1'b0;
  end
  assign hit = alive & col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      alive   <= '0;
      err_q   <= '0;
      acc     <= '0;
      th_q    <= '0;
      win_bid <= '0;
      win_ok  <= 1'b0;
      win_err <= 1'b0;
      irq_n   <= 1'b1;
      cir_q   <= '0;
      for (int s = 0; s < NSRC; s++) snap[s] <= '0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (cnt == '0) begin
        snap  <= bid;
        alive <= src_en;
        err_q <= err_vec;
        th_q  <= thresh;
        acc   <= '0;
      end else if (in_scan) begin
        if (|hit) alive <= hit;
        acc[scan_bit] <= |hit;
      end
      if (last) begin
        win_bid <= acc;
        win_ok  <= |alive;
        win_err <= |(alive & err_q);
        irq_n   <= !((|alive) && (acc > th_q));
      end
      if (iack || upd_cir) cir_q <= {win_ok, win_err, win_bid};
    end
  end

  assign cir_valid = cir_q[BID_W+1];
  assign cir_err   = cir_q[BID_W];
  assign cir_level = cir_q[BID_W-1 -: LV_W];
  assign cir_type  = cir_q[CH_W +: TY_W];
  assign cir_chan  = cir_q[0 +: CH_W];
  assign gsel      = {cir_chan, cir_type};
endmodule

// File: rtl/irq_bid_arbiter_chk.sv
module irq_bid_arbiter_chk #(
  parameter int NSRC      = 12,
  parameter int BID_W     = 10,
  parameter int CNT_W     = 5,
  parameter int ROUND_LEN = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic             iack,
  input logic             upd_cir,
  input logic             win_ok,
  input logic [CNT_W-1:0] cnt,
  input logic [NSRC-1:0]  alive,
  input logic [BID_W+1:0] cir_q
);
  // R6
  round_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != $past(irq_n)) |-> (cnt == '0));

  // R4
  irq_bidder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> win_ok);

  // R1
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(ROUND_LEN - 1)) |-> $onehot0(alive));

  // R1
  scan_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ((alive & ~$past(alive)) == '0));

  // R8
  cir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iack || upd_cir) |=> $stable(cir_q));
endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk #(
  .NSRC(NSRC), .BID_W(BID_W), .CNT_W(CNT_W), .ROUND_LEN(ROUND_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .iack(iack), .upd_cir(upd_cir),
  .win_ok(win_ok), .cnt(cnt), .alive(alive), .cir_q(cir_q)
);

// File: tb/irq_bid_arbiter_bench.sv
module irq_bid_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_en = '0;
  logic [23:0] rx_fill = '0, tx_empty = '0, cos_prio = '0;
  logic [3:0]  rx_err = '0;
  logic [9:0]  thresh = '0;
  logic        iack = 1'b0, upd_cir = 1'b0;
  logic        irq_n, cir_valid, cir_err;
  logic [1:0]  cir_chan, cir_type;
  logic [5:0]  cir_level;
  logic [3:0]  gsel;

  int tests = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  irq_bid_arbiter u_irq_bid_arbiter (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .rx_fill(rx_fill),
    .tx_empty(tx_empty), .cos_prio(cos_prio), .rx_err(rx_err),
    .thresh(thresh), .iack(iack), .upd_cir(upd_cir), .irq_n(irq_n),
    .cir_valid(cir_valid), .cir_err(cir_err), .cir_chan(cir_chan),
    .cir_type(cir_type), .cir_level(cir_level), .gsel(gsel)
  );

  typedef struct packed {
    logic [11:0] en;
    logic [23:0] rx, tx, os;
    logic [3:0]  er;
    logic [9:0]  th;
    logic        irqn, valid;
    logic [1:0]  ch, ty;
    logic [5:0]  lv;
    logic        e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{12'h020, {6'd0,6'd0,6'd10,6'd0}, 24'd0, 24'd0, 4'b0000, 10'd0,    1'b0,1'b1,2'd1,2'd2,6'd10,1'b0},
    '{12'hFFF, {6'd0,6'd3,6'd5,6'd5},  24'd0, 24'd0, 4'b0000, 10'd0,    1'b0,1'b1,2'd1,2'd2,6'd5, 1'b0},
    '{12'hFFF, {6'd19,6'd0,6'd0,6'd0}, {6'd0,6'd20,6'd0,6'd0}, 24'd0, 4'b0000, 10'd0, 1'b0,1'b1,2'd2,2'd1,6'd20,1'b0},
    '{12'hFFF, {6'd39,6'd0,6'd0,6'd0}, 24'd0, {6'd0,6'd0,6'd0,6'd40}, 4'b0000, 10'd0, 1'b0,1'b1,2'd0,2'd0,6'd40,1'b0},
    '{12'hFFE, {6'd39,6'd0,6'd0,6'd0}, 24'd0, {6'd0,6'd0,6'd0,6'd40}, 4'b0000, 10'd0, 1'b0,1'b1,2'd3,2'd2,6'd39,1'b0},
    '{12'hFFF, {6'd0,6'd2,6'd0,6'd0},  24'd0, 24'd0, 4'b0000, 10'd42,   1'b1,1'b1,2'd2,2'd2,6'd2, 1'b0},
    '{12'hFFF, {6'd0,6'd2,6'd0,6'd0},  24'd0, 24'd0, 4'b0000, 10'd41,   1'b0,1'b1,2'd2,2'd2,6'd2, 1'b0},
    '{12'h000, {6'd9,6'd9,6'd9,6'd9},  24'd0, 24'd0, 4'b0000, 10'd0,    1'b1,1'b0,2'd0,2'd0,6'd0, 1'b0},
    '{12'hFFF, {6'd0,6'd0,6'd7,6'd0},  24'd0, 24'd0, 4'b0010, 10'd0,    1'b0,1'b1,2'd1,2'd2,6'd7, 1'b1},
    '{12'hFFF, {6'd0,6'd0,6'd7,6'd0},  {6'd0,6'd0,6'd9,6'd0}, 24'd0, 4'b0010, 10'd0, 1'b0,1'b1,2'd1,2'd1,6'd9,1'b0},
    '{12'hFFF, {6'd0,6'd0,6'd0,6'd12}, {6'd12,6'd0,6'd0,6'd0}, {6'd12,6'd0,6'd0,6'd0}, 4'b0000, 10'd0, 1'b0,1'b1,2'd0,2'd2,6'd12,1'b0},
    '{12'hFFF, {6'd63,6'd0,6'd0,6'd0}, 24'd0, 24'd0, 4'b0000, 10'd1023, 1'b1,1'b1,2'd3,2'd2,6'd63,1'b0},
    '{12'hFFF, {6'd63,6'd0,6'd0,6'd0}, 24'd0, 24'd0, 4'b0000, 10'd1018, 1'b0,1'b1,2'd3,2'd2,6'd63,1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic capture(input logic use_upd);
    if (use_upd) upd_cir = 1'b1; else iack = 1'b1;
    @(negedge clk);
    upd_cir = 1'b0;
    iack = 1'b0;
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 100 && irq_n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R11 reset state
    chk("R11 irq_n", irq_n, 1);
    chk("R11 cir_valid", cir_valid, 0);
    chk("R11 gsel", gsel, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R11 cir_level", cir_level, 0);

    // R1 R2 R3 R4 R5 R8 R9 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      src_en = VECS[v].en; rx_fill = VECS[v].rx; tx_empty = VECS[v].tx;
      cos_prio = VECS[v].os; rx_err = VECS[v].er; thresh = VECS[v].th;
      cyc(50);
      chk("R4 irq_n", irq_n, VECS[v].irqn);
      capture(v[0]);
      chk("R8 R3 cir_valid", cir_valid, VECS[v].valid);
      chk("R1 R5 cir_chan", cir_chan, VECS[v].ch);
      chk("R1 R5 cir_type", cir_type, VECS[v].ty);
      chk("R2 cir_level", cir_level, VECS[v].lv);
      chk("R9 cir_err", cir_err, VECS[v].e);
      chk("R10 gsel", gsel, {VECS[v].ch, VECS[v].ty});
    end

    // R8 hold until next capture
    src_en = '0;
    cyc(50);
    chk("R3 irq_n idle", irq_n, 1);
    chk("R8 hold level", cir_level, 63);
    chk("R8 hold chan", cir_chan, 3);
    capture(1'b1);
    chk("R8 update clears valid", cir_valid, 0);

    // R6 round length: change lands before the next sample
    src_en = 12'h020; rx_fill = {6'd0,6'd0,6'd10,6'd0}; thresh = '0;
    wait_fall();
    chk("R6 fall seen", irq_n, 0);
    src_en = '0;
    cyc(21);
    chk("R6 held through round", irq_n, 0);
    cyc(1);
    chk("R6 released after 22", irq_n, 1);

    // R7 change after sample waits one more round
    src_en = 12'h020;
    wait_fall();
    cyc(2);
    src_en = '0;
    cyc(20);
    chk("R7 mid-round change ignored", irq_n, 0);
    cyc(22);
    chk("R7 change taken next round", irq_n, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule